// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the pending-event flags and the per-source interrupt enables for a timer/counter. The timer runs either as two 8-bit compare channels or as one 16-bit counter. The counter, the comparators and the capture logic sit outside the block. They deliver single-cycle event pulses for compare A, compare B, overflow and input capture. Two mode inputs tell the block when the timer is in 16-bit operation and when it is in capture operation.

In 16-bit operation the compare B register serves as the high byte of the wider value, so compare B events are dropped. In capture operation the compare A register holds the captured count, so compare A events are dropped. The flag register also holds four flags that belong to a neighbouring timer. These share the same register byte and the same write-one-to-clear rule.

Software reaches both registers over a byte-wide register bus. A source raises its interrupt request only when the global enable, its own enable bit and its flag are all set. The block names the single highest-priority pending request. Taking an interrupt is signalled by a per-source acknowledge strobe, and the strobe clears that source's flag.

Top module: `tmr_irq_flags`

## Requirements
- R1: After an asynchronous active-low reset, all flags and all enable bits are 0. The request and grant outputs are 0, and reads of either register return 0x00.
- R2: The register address selects the register: address 0 is the flag register and address 1 is the enable register. The enable register stores only bit 4 (compare A), bit 3 (compare B), bit 1 (overflow) and bit 0 (capture). Its other bits read 0 whatever was written. Reads are combinational.
- R3: A one-cycle event pulse sets its flag, and the flag is visible after the next rising clock edge. The flag positions are: compare A at bit 4, compare B at bit 3, overflow at bit 1, capture at bit 0. The neighbour events nbr_evt_i[0..3] set bits 2, 5, 6 and 7 respectively.
- R4: Writing the flag register clears every bit from 7 down to 1 that is written as 1. Bits written as 0 keep their value.
- R5: Software writes never change the capture flag (bit 0).
- R6: An acknowledge strobe clears only the flag of its own source. The ack_i index mapping is 0 capture, 1 compare A, 2 compare B, 3 overflow.
- R7: When a set event and a clear (software write or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R8: irq_o[k] is 1 exactly when gie_i, source k's enable bit and source k's flag are all 1. The index mapping matches R6.
- R9: While mode_wide_i is 1, compare B events do not set the compare B flag. Compare A events still set the compare A flag.
- R10: While mode_cap_i is 1, compare A events do not set the compare A flag.
- R11: grant_o is one-hot on the highest-priority asserted request, in the order capture, compare A, compare B, overflow. grant_o is 0 when no request is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmpa_evt_i | input | 1 | Compare A match pulse (8-bit or 16-bit match) |
| cmpb_evt_i | input | 1 | Compare B match pulse |
| ovf_evt_i | input | 1 | Counter overflow pulse |
| cap_evt_i | input | 1 | Input capture pulse |
| nbr_evt_i | input | 4 | Event pulses for the neighbour timer's flags |
| mode_wide_i | input | 1 | Timer is in 16-bit operation |
| mode_cap_i | input | 1 | Timer is in capture operation |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 4 | Per-source acknowledge strobes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 4 | Per-source interrupt requests |
| grant_o | output | 4 | One-hot highest-priority pending request |

## Verification
The assertions check several rules on every cycle: that a request never rises without the global enable, and that the grant is at most one-hot, lies inside the request set and is present whenever any request is. They also check that the masked compare events leave their flags clear in 16-bit and capture operation, that an event always leaves its flag set on the next cycle, and that only an acknowledge can lower the capture flag.

The register map, the write-one-to-clear semantics with zero bits ignored, and the enable masking of requests are shown only through the bench's scenarios. The same holds for the exact priority chosen among several pending sources and the reset values.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 1;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned NNBR   = 4;

  // source index = priority order (0 highest)
  localparam int unsigned SRC_CAP  = 0;
  localparam int unsigned SRC_CMPA = 1;
  localparam int unsigned SRC_CMPB = 2;
  localparam int unsigned SRC_OVF  = 3;

  // bit position of each source in flag and enable registers
  localparam int unsigned FPOS_CAP  = 0;
  localparam int unsigned FPOS_OVF  = 1;
  localparam int unsigned FPOS_CMPB = 3;
  localparam int unsigned FPOS_CMPA = 4;

  localparam int unsigned SRC_POS [NSRC] = '{FPOS_CAP, FPOS_CMPA, FPOS_CMPB, FPOS_OVF};
  localparam int unsigned NBR_POS [NNBR] = '{2, 5, 6, 7};

  localparam logic [ADDR_W-1:0] ADDR_FLG = '0;
  localparam logic [ADDR_W-1:0] ADDR_EN  = 1;

  function automatic logic [REG_W-1:0] en_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < NSRC; k++) m[SRC_POS[k]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_irq_flag_bit.sv
module tmr_irq_flag_bit #(
  parameter bit SW_RO = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic sw_clr_i,
  input  logic hw_clr_i,
  output logic flag_o
);
  logic clr;
  logic flag_q;

  generate
    if (SW_RO) begin : g_ro
      assign clr = hw_clr_i;
    end else begin : g_rw
      assign clr = hw_clr_i | sw_clr_i;
    end
  endgenerate

  // set has priority over any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (set_i)    flag_q <= 1'b1;
    else if (clr)      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_irq_en_reg.sv
module tmr_irq_en_reg #(
  parameter int unsigned          W    = 8,
  parameter logic [W-1:0]         MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i & MASK;
  end

  assign en_o = en_q;
endmodule

// File: rtl/tmr_irq_prio.sv
module tmr_irq_prio #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !found) begin
        gnt_o[k] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmpa_evt_i,
  input  logic              cmpb_evt_i,
  input  logic              ovf_evt_i,
  input  logic              cap_evt_i,
  input  logic [NNBR-1:0]   nbr_evt_i,
  input  logic              mode_wide_i,
  input  logic              mode_cap_i,
  input  logic              gie_i,
  input  logic [NSRC-1:0]   ack_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [NSRC-1:0]   irq_o,
  output logic [NSRC-1:0]   grant_o
);
  localparam logic [REG_W-1:0] EN_MASK = en_mask();

  logic [NSRC-1:0]  src_set;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] hw_clr_vec;
  logic [REG_W-1:0] sw_clr_vec;
  logic [REG_W-1:0] flag_q;
  logic [REG_W-1:0] en_q;
  logic             flg_wr;
  logic             en_wr;

  // mode-dependent event masking
  always_comb begin
    src_set           = '0;
    src_set[SRC_CAP]  = cap_evt_i;
    src_set[SRC_CMPA] = cmpa_evt_i & ~mode_cap_i;
    src_set[SRC_CMPB] = cmpb_evt_i & ~mode_wide_i;
    src_set[SRC_OVF]  = ovf_evt_i;
  end

  always_comb begin
    set_vec    = '0;
    hw_clr_vec = '0;
    for (int k = 0; k < NSRC; k++) begin
      set_vec[SRC_POS[k]]    = src_set[k];
      hw_clr_vec[SRC_POS[k]] = ack_i[k];
    end
    for (int j = 0; j < NNBR; j++) set_vec[NBR_POS[j]] = nbr_evt_i[j];
  end

  assign flg_wr     = reg_wr_i && (reg_addr_i == ADDR_FLG);
  assign en_wr      = reg_wr_i && (reg_addr_i == ADDR_EN);
  assign sw_clr_vec = {REG_W{flg_wr}} & reg_wdata_i;

  for (genvar i = 0; i < REG_W; i++) begin : g_flag
    tmr_irq_flag_bit #(
      .SW_RO(i == FPOS_CAP)
    ) u_bit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec[i]),
      .sw_clr_i(sw_clr_vec[i]),
      .hw_clr_i(hw_clr_vec[i]),
      .flag_o  (flag_q[i])
    );
  end

  tmr_irq_en_reg #(
    .W   (REG_W),
    .MASK(EN_MASK)
  ) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (en_wr),
    .wdata_i(reg_wdata_i),
    .en_o   (en_q)
  );

  always_comb begin
    for (int k = 0; k < NSRC; k++)
      irq_o[k] = gie_i & en_q[SRC_POS[k]] & flag_q[SRC_POS[k]];
  end

  tmr_irq_prio #(
    .N(NSRC)
  ) u_prio (
    .req_i(irq_o),
    .gnt_o(grant_o)
  );

  assign reg_rdata_o = (reg_addr_i == ADDR_EN) ? en_q : flag_q;
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk
  import tmr_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmpa_evt_i,
  input logic             cmpb_evt_i,
  input logic             ovf_evt_i,
  input logic             cap_evt_i,
  input logic             mode_wide_i,
  input logic             mode_cap_i,
  input logic             gie_i,
  input logic [NSRC-1:0]  ack_i,
  input logic [NSRC-1:0]  irq_o,
  input logic [NSRC-1:0]  grant_o,
  input logic [REG_W-1:0] flag_q
);
  a_r8_irq_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> gie_i);

  a_r11_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  a_r11_grant_in_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~irq_o) == '0);

  a_r11_grant_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> (grant_o != '0));

  a_r9_cmpb_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wide_i && cmpb_evt_i && !flag_q[FPOS_CMPB]) |=> !flag_q[FPOS_CMPB]);

  a_r10_cmpa_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_cap_i && cmpa_evt_i && !flag_q[FPOS_CMPA]) |=> !flag_q[FPOS_CMPA]);

  a_r7_cap_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> flag_q[FPOS_CAP]);

  a_r7_ovf_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> flag_q[FPOS_OVF]);

  a_r5_cap_sw_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[FPOS_CAP] && !ack_i[SRC_CAP]) |=> flag_q[FPOS_CAP]);
endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmpa_evt_i (cmpa_evt_i),
  .cmpb_evt_i (cmpb_evt_i),
  .ovf_evt_i  (ovf_evt_i),
  .cap_evt_i  (cap_evt_i),
  .mode_wide_i(mode_wide_i),
  .mode_cap_i (mode_cap_i),
  .gie_i      (gie_i),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .grant_o    (grant_o),
  .flag_q     (flag_q)
);

// File: tb/tmr_irq_flags_test.sv
`timescale 1ns/1ps
module tmr_irq_flags_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmpa_evt_i = 0, cmpb_evt_i = 0, ovf_evt_i = 0, cap_evt_i = 0;
  logic [3:0] nbr_evt_i = '0;
  logic       mode_wide_i = 0, mode_cap_i = 0, gie_i = 0;
  logic [3:0] ack_i = '0;
  logic       reg_wr_i = 0;
  logic [0:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [3:0] irq_o, grant_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  tmr_irq_flags uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmpa_evt_i(cmpa_evt_i), .cmpb_evt_i(cmpb_evt_i),
    .ovf_evt_i(ovf_evt_i), .cap_evt_i(cap_evt_i), .nbr_evt_i(nbr_evt_i),
    .mode_wide_i(mode_wide_i), .mode_cap_i(mode_cap_i), .gie_i(gie_i),
    .ack_i(ack_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o), .grant_o(grant_o)
  );

  typedef struct packed {
    logic [3:0] tag;
    logic       cmpa, cmpb, ovf, cap;
    logic [3:0] nbr;
    logic       wide, capm, gie;
    logic [3:0] ack;
    logic       wr, addr;
    logic [7:0] wdata;
    logic [7:0] eflg;
    logic [3:0] eirq, egnt;
  } vec_t;

  localparam int NV = 21;
  // fields: tag, cmpa,cmpb,ovf,cap, nbr, wide,capm,gie, ack, wr,addr, wdata, eflg, eirq, egnt
  localparam vec_t TBL [NV] = '{
    '{4'd3,  1'b0,1'b0,1'b0,1'b1, 4'h0, 1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0, 8'h00, 8'h01, 4'h0, 4'h0}, // R3 capture sets bit0
    '{4'd2,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b0, 4'h0, 1'b1,1'b1, 8'hFF, 8'h01, 4'h0, 4'h0}, // R2 enable write leaves flags
    '{4'd8,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b0,1'b0, 8'h00, 8'h01, 4'h1, 4'h1}, // R8 gie on
    '{4'd11, 1'b1,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b0,1'b0, 8'h00, 8'h11, 4'h3, 4'h1}, // R11 cap over cmpa
    '{4'd3,  1'b0,1'b1,1'b1,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b0,1'b0, 8'h00, 8'h1B, 4'hF, 4'h1}, // R3 cmpb, ovf
    '{4'd6,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h1, 1'b0,1'b0, 8'h00, 8'h1A, 4'hE, 4'h2}, // R6 ack capture only
    '{4'd4,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b1,1'b0, 8'h00, 8'h1A, 4'hE, 4'h2}, // R4 write zeros no effect
    '{4'd4,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b1,1'b0, 8'h10, 8'h0A, 4'hC, 4'h4}, // R4 clear cmpa
    '{4'd4,  1'b0,1'b0,1'b0,1'b1, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b1,1'b0, 8'h08, 8'h03, 4'h9, 4'h1}, // R4 clear cmpb, cap set
    '{4'd5,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b1,1'b0, 8'h01, 8'h03, 4'h9, 4'h1}, // R5 cap not writable
    '{4'd7,  1'b0,1'b0,1'b1,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b1,1'b0, 8'h02, 8'h03, 4'h9, 4'h1}, // R7 set beats sw clear
    '{4'd7,  1'b0,1'b0,1'b1,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h8, 1'b0,1'b0, 8'h00, 8'h03, 4'h9, 4'h1}, // R7 set beats ack
    '{4'd6,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h8, 1'b0,1'b0, 8'h00, 8'h01, 4'h1, 4'h1}, // R6 ack ovf
    '{4'd8,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0, 8'h00, 8'h01, 4'h0, 4'h0}, // R8 gie off
    '{4'd9,  1'b1,1'b1,1'b0,1'b0, 4'h0, 1'b1,1'b0,1'b1, 4'h0, 1'b0,1'b0, 8'h00, 8'h11, 4'h3, 4'h1}, // R9 wide masks cmpb
    '{4'd10, 1'b1,1'b1,1'b0,1'b0, 4'h0, 1'b0,1'b1,1'b1, 4'h0, 1'b1,1'b0, 8'h10, 8'h09, 4'h5, 4'h1}, // R10 capture masks cmpa
    '{4'd3,  1'b0,1'b0,1'b0,1'b0, 4'hF, 1'b0,1'b1,1'b1, 4'h0, 1'b0,1'b0, 8'h00, 8'hED, 4'h5, 4'h1}, // R3 neighbour bits
    '{4'd4,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b1,1'b0, 8'hFF, 8'h01, 4'h1, 4'h1}, // R4 clear all writable
    '{4'd6,  1'b0,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h1, 1'b0,1'b0, 8'h00, 8'h00, 4'h0, 4'h0}, // R6 ack clears cap
    '{4'd11, 1'b0,1'b0,1'b1,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b0,1'b0, 8'h00, 8'h02, 4'h8, 4'h8}, // R11 lowest priority alone
    '{4'd8,  1'b1,1'b0,1'b0,1'b0, 4'h0, 1'b0,1'b0,1'b1, 4'h0, 1'b1,1'b1, 8'h02, 8'h12, 4'h8, 4'h8}  // R8 enable masks cmpa
  };

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cmpa_evt_i = 0; cmpb_evt_i = 0; ovf_evt_i = 0; cap_evt_i = 0;
    nbr_evt_i = '0; ack_i = '0; reg_wr_i = 0; reg_addr_i = '0; reg_wdata_i = '0;
  endtask

  task automatic cycle();
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
    #1;
  endtask

  initial begin
    #(5ns * 100000);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    #12;
    // R1 reset state
    check("R1", "flags", reg_rdata_o, 8'h00);
    reg_addr_i = 1'b1; #1;
    check("R1", "enables", reg_rdata_o, 8'h00);
    check("R1", "irq", {4'h0, irq_o}, 8'h00);
    check("R1", "grant", {4'h0, grant_o}, 8'h00);
    reg_addr_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v = TBL[i];
      rq = $sformatf("R%0d", v.tag);
      cmpa_evt_i = v.cmpa; cmpb_evt_i = v.cmpb; ovf_evt_i = v.ovf; cap_evt_i = v.cap;
      nbr_evt_i = v.nbr; mode_wide_i = v.wide; mode_cap_i = v.capm; gie_i = v.gie;
      ack_i = v.ack; reg_wr_i = v.wr; reg_addr_i = v.addr; reg_wdata_i = v.wdata;
      cycle();
      check(rq, $sformatf("vec%0d flags", i), reg_rdata_o, v.eflg);
      check(rq, $sformatf("vec%0d irq", i), {4'h0, irq_o}, {4'h0, v.eirq});
      check(rq, $sformatf("vec%0d grant", i), {4'h0, grant_o}, {4'h0, v.egnt});
    end

    // R2 enable readback after masked writes
    reg_addr_i = 1'b1; #1;
    check("R2", "enable readback", reg_rdata_o, 8'h02);
    reg_wr_i = 1'b1; reg_addr_i = 1'b1; reg_wdata_i = 8'hFF;
    cycle();
    reg_addr_i = 1'b1; #1;
    check("R2", "enable unused bits", reg_rdata_o, 8'h1B);
    reg_addr_i = 1'b0; #1;
    check("R2", "flags unchanged", reg_rdata_o, 8'h12);
    check("R8", "all enabled irq", {4'h0, irq_o}, 8'h0A);
    check("R11", "cmpa over ovf", {4'h0, grant_o}, 8'h02);

    // R1 asynchronous reset mid-run
    #0.5 rst_ni = 1'b0; #1;
    check("R1", "flags after reset", reg_rdata_o, 8'h00);
    check("R1", "irq after reset", {4'h0, irq_o}, 8'h00);
    reg_addr_i = 1'b1; #1;
    check("R1", "enables after reset", reg_rdata_o, 8'h00);
    reg_addr_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule